// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block drives the seven bus cycles that carry an 8-bit processor from its current instruction stream into an interrupt handler. It serves three entry causes: a maskable request, a non-maskable request and the software break opcode. On a start pulse it latches the program counter, the processor flags and the stack pointer. It then issues two dummy reads and three stack pushes: the return address high byte, the return address low byte and a status byte. It ends with a two-byte read of the handler vector. The new program counter and the final stack pointer are presented at its outputs.

The break cause differs in two ways. Its return address skips one padding byte, and its pushed status has the break bit set. A non-maskable request that is pending while a break pushes its status takes over the vector fetch. The sequencer acknowledges that request so the external edge latch can clear. When a break fetches its own vector, the sequencer instead raises a one-cycle hold that delays recognition of a non-maskable request. The surrounding core supplies `nmi_pend` from its edge detector. It also uses `iflag_set` to set its interrupt-disable flag.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `rd`, `wr`, `done`, `iflag_set`, `nmi_ack` and `nmi_hold` are all low.
- R2: `start` is accepted only while `busy` is low. An accepted start makes `busy` high for exactly seven cycles, and `done` is high only in the seventh. A `start` seen while busy changes nothing in the running sequence. Cause encoding: 2'b00 maskable, 2'b01 non-maskable, 2'b10 break, 2'b11 treated as maskable.
- R3: The first two cycles are reads. For the maskable and non-maskable causes both reads are at the latched PC. For break they are at PC and PC+1, and the return address is PC+2 (modulo 65536).
- R4: Cycles three to five are writes to address 0x0100 | SP, with SP decremented after each write (modulo 256). The bytes are the return address high byte, then its low byte, then the status. After the sequence `sp_out` equals the start SP minus 3.
- R5: The status byte has bit 7 = N, bit 6 = V, bit 5 = 1, bit 4 = break cause, bit 3 = D, bit 2 = I, bit 1 = Z and bit 0 = C. `flags_in` supplies these flags as {N,V,D,I,Z,C} in bits 5..0.
- R6: `iflag_set` is high exactly in the status write cycle.
- R7: Cycles six and seven read the vector low byte, then the high byte. The vector is at 0xFFFE/0xFFFF for the maskable and break causes and at 0xFFFA/0xFFFB for the non-maskable cause. From the cycle after `done`, `pc_out` holds {high byte, low byte}.
- R8: A break that sees `nmi_pend` high in its status write cycle pulses `nmi_ack` in that cycle and fetches the non-maskable vector, still in seven cycles. The maskable and non-maskable causes ignore `nmi_pend` and never pulse `nmi_ack`.
- R9: A break that fetches its own vector pulses `nmi_hold` during the vector low read cycle. `nmi_hold` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an entry sequence |
| cause | input | 2 | Entry cause, latched with start |
| pc_in | input | 16 | Current program counter |
| flags_in | input | 6 | Flags {N,V,D,I,Z,C} |
| sp_in | input | 8 | Current stack pointer |
| nmi_pend | input | 1 | Pending non-maskable request |
| rdata | input | 8 | Read data for the current bus cycle |
| addr | output | 16 | Bus address |
| rd | output | 1 | Read cycle |
| wr | output | 1 | Write cycle |
| wdata | output | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of the sequence |
| iflag_set | output | 1 | Set the interrupt-disable flag |
| nmi_ack | output | 1 | Pending non-maskable request consumed |
| nmi_hold | output | 1 | Delay non-maskable recognition one cycle |
| pc_out | output | 16 | Working / new program counter |
| sp_out | output | 8 | Working / final stack pointer |

## Verification
The hardest case to reach is the takeover. A break must find `nmi_pend` high in exactly its fifth cycle, and the result is visible only in the vector addresses and `nmi_ack`. The stimulus holds `nmi_pend` at a random level across whole sequences of every cause, so breaks with and without takeover and maskable requests with a pending non-maskable request all occur. Directed cases add a stack pointer that wraps through 0x00 and a break at 0xFFFF whose return address wraps. A further directed case keeps `start` asserted with different inputs while busy.

// File: rtl/irq_entry_pkg.sv
`timescale 1ns/1ps
package irq_entry_pkg;
   typedef enum logic [1:0] {
      CAUSE_IRQ = 2'b00,
      CAUSE_NMI = 2'b01,
      CAUSE_BRK = 2'b10,
      CAUSE_RSV = 2'b11
   } cause_e;

   localparam int unsigned SEQ_LEN = 7;

   typedef enum logic [2:0] {
      ST_DUMMY0  = 3'd0,
      ST_DUMMY1  = 3'd1,
      ST_PUSH_HI = 3'd2,
      ST_PUSH_LO = 3'd3,
      ST_PUSH_P  = 3'd4,
      ST_VEC_LO  = 3'd5,
      ST_VEC_HI  = 3'd6
   } step_e;

   // status byte image: N V 1 B D I Z C
   function automatic logic [7:0] pack_status(input logic [5:0] f, input logic brk);
      return {f[5], f[4], 1'b1, brk, f[3], f[2], f[1], f[0]};
   endfunction
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
   import irq_entry_pkg::*;
#(
   parameter bit TAKEOVER_EN = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   input  logic  [1:0] cause,
   input  logic  nmi_pend,
   output logic  start_acc,
   output logic  busy,
   output step_e step,
   output logic  is_brk,
   output logic  use_nmi_vec,
   output logic  done,
   output logic  iflag_set,
   output logic  nmi_ack,
   output logic  nmi_hold
);
   logic  busy_q, brk_q, nmi_vec_q;
   step_e step_q;
   logic  takeover;
   cause_e cause_c;

   assign cause_c   = cause_e'(cause);
   assign start_acc = start && !busy_q;

   generate
      if (TAKEOVER_EN) begin : g_takeover
         assign takeover = busy_q && brk_q && nmi_pend && (step_q == ST_PUSH_P);
      end else begin : g_no_takeover
         assign takeover = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         step_q    <= ST_DUMMY0;
         brk_q     <= 1'b0;
         nmi_vec_q <= 1'b0;
      end else if (start_acc) begin
         busy_q    <= 1'b1;
         step_q    <= ST_DUMMY0;
         brk_q     <= (cause_c == CAUSE_BRK);
         nmi_vec_q <= (cause_c == CAUSE_NMI);
      end else if (busy_q) begin
         if (step_q == ST_VEC_HI) begin
            busy_q <= 1'b0;
            step_q <= ST_DUMMY0;
         end else begin
            step_q <= step_e'(step_q + 3'd1);
         end
         if (takeover) nmi_vec_q <= 1'b1;
      end
   end

   assign busy        = busy_q;
   assign step        = step_q;
   assign is_brk      = brk_q;
   assign use_nmi_vec = nmi_vec_q;
   assign done        = busy_q && (step_q == ST_VEC_HI);
   assign iflag_set   = busy_q && (step_q == ST_PUSH_P);
   assign nmi_ack     = takeover;
   assign nmi_hold    = busy_q && brk_q && !nmi_vec_q && (step_q == ST_VEC_LO);
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned FLAG_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_acc,
   input  logic              busy,
   input  step_e             step,
   input  logic              is_brk,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [FLAG_W-1:0] flags_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] pc_q,
   output logic [DATA_W-1:0] sp_q,
   output logic [FLAG_W-1:0] flags_q
);
   logic [DATA_W-1:0] vec_lo_q;
   logic              push_step;

   assign push_step = (step == ST_PUSH_HI) || (step == ST_PUSH_LO) || (step == ST_PUSH_P);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= '0;
         sp_q     <= '0;
         flags_q  <= '0;
         vec_lo_q <= '0;
      end else if (start_acc) begin
         pc_q    <= pc_in;
         sp_q    <= sp_in;
         flags_q <= flags_in;
      end else if (busy) begin
         if (is_brk && (step == ST_DUMMY0 || step == ST_DUMMY1))
            pc_q <= pc_q + ADDR_W'(1);
         if (push_step)
            sp_q <= sp_q - DATA_W'(1);
         if (step == ST_VEC_LO)
            vec_lo_q <= rdata;
         if (step == ST_VEC_HI)
            pc_q <= {rdata, vec_lo_q};
      end
   end
endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned FLAG_W = 6,
   parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
   parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE
) (
   input  logic              busy,
   input  step_e             step,
   input  logic              is_brk,
   input  logic              use_nmi_vec,
   input  logic [ADDR_W-1:0] pc_q,
   input  logic [DATA_W-1:0] sp_q,
   input  logic [FLAG_W-1:0] flags_q,
   output logic [ADDR_W-1:0] addr,
   output logic              rd,
   output logic              wr,
   output logic [DATA_W-1:0] wdata
);
   logic [ADDR_W-1:0] vec_base;
   logic [ADDR_W-1:0] stack_addr;
   logic              write_step;

   assign vec_base   = use_nmi_vec ? VEC_NMI : VEC_IRQ;
   assign stack_addr = {STACK_PAGE, sp_q};
   assign write_step = (step == ST_PUSH_HI) || (step == ST_PUSH_LO) || (step == ST_PUSH_P);
   assign wr         = busy && write_step;
   assign rd         = busy && !write_step;

   always_comb begin
      addr  = '0;
      wdata = '0;
      if (busy) begin
         unique case (step)
            ST_DUMMY0, ST_DUMMY1: addr = pc_q;
            ST_PUSH_HI: begin addr = stack_addr; wdata = pc_q[ADDR_W-1:DATA_W]; end
            ST_PUSH_LO: begin addr = stack_addr; wdata = pc_q[DATA_W-1:0]; end
            ST_PUSH_P:  begin addr = stack_addr; wdata = pack_status(flags_q, is_brk); end
            ST_VEC_LO:  addr = vec_base;
            ST_VEC_HI:  addr = vec_base + ADDR_W'(1);
            default:    addr = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [7:0]  STACK_PAGE = 8'h01,
   parameter logic [15:0] VEC_NMI = 16'hFFFA,
   parameter logic [15:0] VEC_IRQ = 16'hFFFE,
   parameter bit          TAKEOVER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        cause,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [5:0]        flags_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic              nmi_pend,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr,
   output logic              rd,
   output logic              wr,
   output logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              done,
   output logic              iflag_set,
   output logic              nmi_ack,
   output logic              nmi_hold,
   output logic [ADDR_W-1:0] pc_out,
   output logic [DATA_W-1:0] sp_out
);
   localparam int unsigned FLAG_W = 6;

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("irq_entry_seq: DATA_W must be 8");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
         $error("irq_entry_seq: ADDR_W must be twice DATA_W");
      end
      if (VEC_NMI[0] || VEC_IRQ[0]) begin : g_bad_vec
         $error("irq_entry_seq: vectors must be even");
      end
   endgenerate

   logic              start_acc, is_brk, use_nmi_vec;
   step_e             step;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] sp_q;
   logic [FLAG_W-1:0] flags_q;

   irq_seq_ctrl #(.TAKEOVER_EN(TAKEOVER_EN)) u_ctrl (
      .clk, .rst_n, .start, .cause, .nmi_pend,
      .start_acc, .busy, .step, .is_brk, .use_nmi_vec,
      .done, .iflag_set, .nmi_ack, .nmi_hold
   );

   irq_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_regs (
      .clk, .rst_n, .start_acc, .busy, .step, .is_brk,
      .pc_in, .flags_in, .sp_in, .rdata,
      .pc_q, .sp_q, .flags_q
   );

   irq_seq_bus #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W),
      .STACK_PAGE(STACK_PAGE[DATA_W-1:0]),
      .VEC_NMI(VEC_NMI[ADDR_W-1:0]), .VEC_IRQ(VEC_IRQ[ADDR_W-1:0])
   ) u_bus (
      .busy, .step, .is_brk, .use_nmi_vec,
      .pc_q, .sp_q, .flags_q,
      .addr, .rd, .wr, .wdata
   );

   assign pc_out = pc_q;
   assign sp_out = sp_q;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter logic [7:0]  STACK_PAGE = 8'h01,
   parameter logic [15:0] VEC_IRQ = 16'hFFFE
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] addr,
   input logic              rd,
   input logic              wr,
   input logic              busy,
   input logic              done,
   input logic              iflag_set,
   input logic              nmi_ack,
   input logic              nmi_hold,
   input logic [DATA_W-1:0] sp_out
);
   a_r2_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(rd && wr));
   a_r2_done_in_busy:    assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
   a_r2_start_idle:      assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
   a_r2_done_ends:       assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
   a_r4_stack_page:      assert property (@(posedge clk) disable iff (!rst_n)
                                          wr |-> (addr[ADDR_W-1:DATA_W] == STACK_PAGE[DATA_W-1:0]));
   a_r4_sp_dec:          assert property (@(posedge clk) disable iff (!rst_n)
                                          wr |=> (sp_out == $past(sp_out) - DATA_W'(1)));
   a_r6_iset_on_write:   assert property (@(posedge clk) disable iff (!rst_n) iflag_set |-> wr);
   a_r8_ack_in_push:     assert property (@(posedge clk) disable iff (!rst_n) nmi_ack |-> iflag_set);
   a_r9_hold_own_vec:    assert property (@(posedge clk) disable iff (!rst_n)
                                          nmi_hold |-> (rd && addr == VEC_IRQ[ADDR_W-1:0]));
   a_r9_hold_single:     assert property (@(posedge clk) disable iff (!rst_n) nmi_hold |=> !nmi_hold);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STACK_PAGE(STACK_PAGE), .VEC_IRQ(VEC_IRQ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .rd(rd), .wr(wr),
   .busy(busy), .done(done), .iflag_set(iflag_set), .nmi_ack(nmi_ack),
   .nmi_hold(nmi_hold), .sp_out(sp_out)
);

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  cause = 2'b00;
   logic [15:0] pc_in = '0;
   logic [5:0]  flags_in = '0;
   logic [7:0]  sp_in = '0;
   logic        nmi_pend = 1'b0;
   logic [7:0]  rdata;
   logic [15:0] addr, pc_out;
   logic        rd, wr, busy, done, iflag_set, nmi_ack, nmi_hold;
   logic [7:0]  wdata, sp_out;

   int vecs = 0;
   int errs = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] mem(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hC3;
   endfunction

   assign rdata = mem(addr);

   irq_entry_seq u_irq_entry_seq (
      .clk, .rst_n, .start, .cause, .pc_in, .flags_in, .sp_in, .nmi_pend, .rdata,
      .addr, .rd, .wr, .wdata, .busy, .done, .iflag_set, .nmi_ack, .nmi_hold,
      .pc_out, .sp_out
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run(input logic [1:0] c, input logic [15:0] p, input logic [5:0] f,
                      input logic [7:0] s, input bit nmi, input bit poke);
      logic        brk, nmiv;
      logic [15:0] ret, vec, ea;
      logic [7:0]  ed;
      brk  = (c == 2'b10);
      nmiv = (c == 2'b01) || (brk && nmi);
      ret  = brk ? p + 16'd2 : p;
      vec  = nmiv ? 16'hFFFA : 16'hFFFE;
      @(negedge clk);
      start = 1'b1; cause = c; pc_in = p; flags_in = f; sp_in = s; nmi_pend = nmi;
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         if (poke && k < 6) begin
            start = 1'b1; cause = ~c; pc_in = ~p; sp_in = ~s; flags_in = ~f;
         end else begin
            start = 1'b0;
         end
         #1;
         ed = 8'h00;
         case (k)
            0: ea = p;
            1: ea = brk ? p + 16'd1 : p;
            2: begin ea = {8'h01, s};         ed = ret[15:8]; end
            3: begin ea = {8'h01, s - 8'd1};  ed = ret[7:0]; end
            4: begin ea = {8'h01, s - 8'd2};
                     ed = {f[5], f[4], 1'b1, brk, f[3:0]}; end
            5: ea = vec;
            default: ea = vec + 16'd1;
         endcase
         check("R2 busy", {31'd0, busy}, 32'd1);
         check("R2 done", {31'd0, done}, {31'd0, k == 6});
         check(k < 2 ? "R3 addr" : (k < 5 ? "R4 addr" : "R7 addr"), {16'd0, addr}, {16'd0, ea});
         check("R4 rd/wr", {30'd0, rd, wr}, (k >= 2 && k <= 4) ? 32'd1 : 32'd2);
         if (k >= 2 && k <= 4)
            check(k == 4 ? "R5 status" : "R4 wdata", {24'd0, wdata}, {24'd0, ed});
         check("R6 iflag_set", {31'd0, iflag_set}, {31'd0, k == 4});
         check("R8 nmi_ack", {31'd0, nmi_ack}, {31'd0, k == 4 && brk && nmi});
         check("R9 nmi_hold", {31'd0, nmi_hold}, {31'd0, k == 5 && brk && !nmi});
      end
      @(negedge clk); #1;
      check("R2 idle after", {31'd0, busy}, 32'd0);
      check("R7 pc_out", {16'd0, pc_out}, {16'd0, mem(vec + 16'd1), mem(vec)});
      check("R4 sp_out", {24'd0, sp_out}, {24'd0, s - 8'd3});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 rd/wr", {30'd0, rd, wr}, 32'd0);
      check("R1 pulses", {28'd0, done, iflag_set, nmi_ack, nmi_hold}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // directed corners
      run(2'b00, 16'h1234, 6'b101010, 8'hFD, 1'b1, 1'b0); // R8 maskable ignores pending
      run(2'b01, 16'h8000, 6'b010101, 8'h80, 1'b0, 1'b0); // R7 non-maskable vector
      run(2'b10, 16'h4000, 6'b111111, 8'h40, 1'b0, 1'b0); // R9 break own vector
      run(2'b10, 16'h4000, 6'b000000, 8'h40, 1'b1, 1'b0); // R8 takeover
      run(2'b00, 16'h0001, 6'b000100, 8'h01, 1'b0, 1'b0); // R4 stack wrap
      run(2'b10, 16'hFFFF, 6'b100001, 8'h00, 1'b0, 1'b0); // R3 return wrap
      run(2'b11, 16'h2222, 6'b011000, 8'h10, 1'b1, 1'b0); // R2 reserved as maskable
      run(2'b01, 16'hABCD, 6'b110011, 8'h22, 1'b0, 1'b1); // R2 start ignored while busy
      run(2'b10, 16'h5678, 6'b001100, 8'h33, 1'b1, 1'b1); // R2 poke during takeover
      // random mix
      for (int i = 0; i < 300; i++) begin
         run(2'($urandom_range(0, 3)), 16'($urandom), 6'($urandom), 8'($urandom),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) == 0));
         if ($urandom_range(0, 3) == 0) begin
            @(negedge clk); #1;
            check("R2 stays idle", {31'd0, busy}, 32'd0);
         end
      end
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule